// File: doc/BRIEF.md
# Scatter-Gather DMA Channel with Byte Realignment

This block is one DMA channel. It walks a linked list of descriptors in memory and copies one segment for each descriptor. A segment has its own source byte address, destination byte address and byte count. The two addresses need not be aligned to a word, and neither needs the same alignment as the other. The count may be any number of bytes, zero included.

The channel reads source words through a word-addressed memory port. A byte holding buffer two words deep collects the wanted bytes in stream order. The channel then writes destination words with byte enables, so that a partial first or last word never disturbs the bytes next to the segment.

After each segment the channel sets a done bit in the descriptor's control word. If that descriptor asks for it, the channel also raises an interrupt. It then either follows the next pointer or stops at an end-of-chain marker. Software starts the channel by setting a head pointer and an enable bit. Clearing the enable bit halts the channel at the next word access boundary.

Top module: `sgdma_chan`

## Requirements
- R1: Writing 1 to bit 0 of register 0 while the channel is idle starts a chain. The chain starts at the byte address held in register 1, and that register reads back the value written to it. Each descriptor is five words at a word-aligned address, with byte offsets as follows: +0 source byte address, +4 destination byte address, +8 byte count, +12 next-descriptor byte address, +16 control word.
- R2: Each byte of a segment is copied from source address s+i to destination address d+i, for every source alignment s mod 4.
- R3: The copy is correct for every destination alignment d mod 4, and this holds independently of the source alignment.
- R4: Any byte count is copied exactly. Destination bytes outside [d, d+count) are never modified, because partial first and last words are written with byte enables.
- R5: When a descriptor completes and bit 1 (end-of-chain) of its control word is clear, the channel fetches the descriptor at the next pointer. When that bit is set, the channel stops.
- R6: A descriptor with a byte count of zero makes no source or destination access. Its processing is exactly 5 descriptor reads plus 1 control-word write.
- R7: On completion the control word is written back with bit 31 set and all other bits unchanged.
- R8: On completion of a descriptor whose control bit 0 is set, status bit 0 (register 2) and `irq_o` go high. When that bit is clear, neither is set. Writing 1 to register 2 bit 0 clears the pending interrupt.
- R9: Status bit 1 reads 1 while the channel is busy. Status bit 2 is set when an end-of-chain descriptor completes, and is cleared by the next start.
- R10: Writing 0 to register 0 bit 0 halts the channel. It issues no new memory request after the access in flight, it writes back no done bit, busy clears, and it raises no interrupt.
- R11: A memory request holds its address and direction until it is granted. Only one access is outstanding at a time.
- R12: After reset the channel is idle, `irq_o` is low, `mem_req_o` is low and all status bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr_i | input | 1 | Register write strobe |
| csr_addr_i | input | 2 | Register select: 0 control, 1 head pointer, 2 status |
| csr_wdata_i | input | 32 | Register write data |
| csr_rdata_o | output | 32 | Register read data (combinational from the select) |
| irq_o | output | 1 | Completion interrupt, level |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 for a write, 0 for a read |
| mem_addr_o | output | 30 | Word address |
| mem_wdata_o | output | 32 | Write data |
| mem_be_o | output | 4 | Byte enables for writes |
| mem_gnt_i | input | 1 | Request accepted in this cycle |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |

## Verification
A start written on one clock edge shows as busy in status one cycle later. The bench reads that status at the next falling edge. Interrupt and status bits change on the edge that grants the control-word writeback. A clear written to status drops `irq_o` on the edge that captures the write, so the bench samples it at the falling edge that follows. The memory model grants requests on a pseudo-random pattern, which moves the cycle of completion. For that reason the bench polls status until the end-of-chain bit is set, with a bound, before it compares memory. It checks a halt by counting granted accesses over a fixed quiet window after busy clears.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_DRD,
      S_DRV,
      S_SETUP,
      S_XFER,
      S_RD,
      S_RDV,
      S_WR,
      S_WB
   } dma_state_e;

   localparam int DESC_WORDS = 5;
   localparam int DW_SRC     = 0;
   localparam int DW_DST     = 1;
   localparam int DW_LEN     = 2;
   localparam int DW_NEXT    = 3;
   localparam int DW_CTL     = 4;

   localparam int CTL_IRQ    = 0;
   localparam int CTL_EOC    = 1;

   localparam logic [1:0] REG_CTRL = 2'd0;
   localparam logic [1:0] REG_HEAD = 2'd1;
   localparam logic [1:0] REG_STAT = 2'd2;

endpackage

// File: rtl/sgdma_align.sv
module sgdma_align #(
   parameter int NB        = 4,
   parameter int HOLD_WORDS = 2,
   localparam int DW       = 8 * NB,
   localparam int LB       = $clog2(NB),
   localparam int SLOTS    = HOLD_WORDS * NB,
   localparam int CNTW     = $clog2(SLOTS + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr_i,
   input  logic            push_i,
   input  logic [DW-1:0]   push_data_i,
   input  logic [LB-1:0]   push_off_i,
   input  logic [CNTW-1:0] push_n_i,
   input  logic            pop_i,
   input  logic [CNTW-1:0] wcnt_i,
   input  logic [LB-1:0]   dst_off_i,
   output logic [CNTW-1:0] cnt_o,
   output logic [DW-1:0]   wdata_o,
   output logic [NB-1:0]   be_o
);

   localparam int SIW = $clog2(SLOTS);

   generate
      if (HOLD_WORDS < 2) begin : g_bad_depth
         $error("sgdma_align: HOLD_WORDS must be at least 2");
      end
   endgenerate

   logic [7:0]      slot_q [SLOTS];
   logic [7:0]      slot_d [SLOTS];
   logic [7:0]      lane   [NB];
   logic [CNTW-1:0] cnt_q, cnt_d;

   genvar g;
   generate
      for (g = 0; g < NB; g++) begin : g_lane
         assign lane[g] = push_data_i[8*g +: 8];
         assign be_o[g] = (g >= int'(dst_off_i)) &&
                          (g <  int'(dst_off_i) + int'(wcnt_i));
      end
   endgenerate

   always_comb begin
      slot_d = slot_q;
      cnt_d  = cnt_q;
      if (clr_i) begin
         cnt_d = '0;
      end else if (pop_i) begin
         for (int i = 0; i < SLOTS; i++) begin
            if (i + int'(wcnt_i) < SLOTS)
               slot_d[i] = slot_q[SIW'(i + int'(wcnt_i))];
            else
               slot_d[i] = 8'h00;
         end
         cnt_d = cnt_q - wcnt_i;
      end else if (push_i) begin
         for (int j = 0; j < NB; j++) begin
            if (j < int'(push_n_i) && int'(push_off_i) + j < NB &&
                int'(cnt_q) + j < SLOTS)
               slot_d[SIW'(int'(cnt_q) + j)] = lane[LB'(int'(push_off_i) + j)];
         end
         cnt_d = cnt_q + push_n_i;
      end
   end

   always_comb begin
      wdata_o = '0;
      for (int j = 0; j < NB; j++) begin
         if (j >= int'(dst_off_i))
            wdata_o[8*j +: 8] = slot_q[SIW'(j - int'(dst_off_i))];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         for (int i = 0; i < SLOTS; i++) slot_q[i] <= 8'h00;
      end else begin
         cnt_q <= cnt_d;
         for (int i = 0; i < SLOTS; i++) slot_q[i] <= slot_d[i];
      end
   end

   assign cnt_o = cnt_q;

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt_q) <= SLOTS);                                        // R2
   AST_POP_COVERED: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> wcnt_i <= cnt_q);                                   // R4
   AST_PUSH_FITS: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> int'(cnt_q) + int'(push_n_i) <= SLOTS);            // R3

endmodule

// File: rtl/sgdma_csr.sv
module sgdma_csr
   import sgdma_pkg::*;
#(
   parameter int DW     = 32,
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_wr_i,
   input  logic [1:0]        csr_addr_i,
   input  logic [DW-1:0]     csr_wdata_i,
   output logic [DW-1:0]     csr_rdata_o,
   input  logic              busy_i,
   input  logic              set_irq_i,
   input  logic              set_eoc_i,
   output logic              start_o,
   output logic              en_o,
   output logic [ADDR_W-1:0] head_o,
   output logic              irq_o
);

   logic              en_q;
   logic [ADDR_W-1:0] head_q;
   logic              pend_q;
   logic              eoc_q;
   logic              wr_ctrl, wr_head, wr_stat;
   logic              unused_wdata;

   assign wr_ctrl = csr_wr_i && (csr_addr_i == REG_CTRL);
   assign wr_head = csr_wr_i && (csr_addr_i == REG_HEAD);
   assign wr_stat = csr_wr_i && (csr_addr_i == REG_STAT);
   assign start_o = wr_ctrl && csr_wdata_i[0] && !busy_i;
   assign unused_wdata = ^csr_wdata_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         head_q <= '0;
         pend_q <= 1'b0;
         eoc_q  <= 1'b0;
      end else begin
         if (wr_ctrl) en_q <= csr_wdata_i[0];
         if (wr_head) head_q <= csr_wdata_i[ADDR_W-1:0];
         if (set_irq_i)
            pend_q <= 1'b1;
         else if (wr_stat && csr_wdata_i[0])
            pend_q <= 1'b0;
         if (start_o)
            eoc_q <= 1'b0;
         else if (set_eoc_i)
            eoc_q <= 1'b1;
      end
   end

   always_comb begin
      case (csr_addr_i)
         REG_CTRL: csr_rdata_o = DW'(en_q);
         REG_HEAD: csr_rdata_o = DW'(head_q);
         REG_STAT: csr_rdata_o = DW'({eoc_q, busy_i, pend_q});
         default:  csr_rdata_o = '0;
      endcase
   end

   assign en_o   = en_q;
   assign head_o = head_q;
   assign irq_o  = pend_q;

   AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(set_irq_i));                           // R8
   AST_EOC_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eoc_q) |-> $past(set_eoc_i));                           // R9

endmodule

// File: rtl/sgdma_ctrl.sv
module sgdma_ctrl
   import sgdma_pkg::*;
#(
   parameter int NB         = 4,
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 16,
   parameter int HOLD_WORDS = 2,
   localparam int DW        = 8 * NB,
   localparam int LB        = $clog2(NB),
   localparam int WAW       = ADDR_W - LB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              en_i,
   input  logic [ADDR_W-1:0] head_i,
   output logic              busy_o,
   output logic              set_irq_o,
   output logic              set_eoc_o,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [WAW-1:0]    mem_addr_o,
   output logic [DW-1:0]     mem_wdata_o,
   output logic [NB-1:0]     mem_be_o,
   input  logic              mem_gnt_i,
   input  logic              mem_rvalid_i,
   input  logic [DW-1:0]     mem_rdata_i
);

   localparam int SLOTS = HOLD_WORDS * NB;
   localparam int CNTW  = $clog2(SLOTS + 1);
   localparam int IDXW  = $clog2(DESC_WORDS);

   dma_state_e        state_q;
   logic [IDXW-1:0]   idx_q;
   logic [WAW-1:0]    dptr_q;
   logic [ADDR_W-1:0] rd_addr_q, wr_addr_q, nxt_q;
   logic [LEN_W-1:0]  rd_left_q, wr_left_q;
   logic [DW-1:0]     ctl_q;

   logic [LB-1:0]     soff, doff;
   logic [LEN_W-1:0]  rd_room, wr_room, rd_take, wr_take;
   logic [CNTW-1:0]   al_cnt;
   logic [DW-1:0]     al_wdata;
   logic [NB-1:0]     al_be;
   logic              can_wr;
   logic              al_clr, al_push, al_pop;
   logic              unused_low;

   assign unused_low = ^{head_i[LB-1:0], nxt_q[LB-1:0]};

   assign soff    = rd_addr_q[LB-1:0];
   assign doff    = wr_addr_q[LB-1:0];
   assign rd_room = LEN_W'(NB) - LEN_W'(soff);
   assign wr_room = LEN_W'(NB) - LEN_W'(doff);
   assign rd_take = (rd_left_q < rd_room) ? rd_left_q : rd_room;
   assign wr_take = (wr_left_q < wr_room) ? wr_left_q : wr_room;
   assign can_wr  = LEN_W'(al_cnt) >= wr_take;

   assign al_clr  = (state_q == S_SETUP);
   assign al_push = (state_q == S_RDV) && mem_rvalid_i;
   assign al_pop  = (state_q == S_WR) && mem_gnt_i;

   sgdma_align #(
      .NB        (NB),
      .HOLD_WORDS(HOLD_WORDS)
   ) u_align (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (al_clr),
      .push_i     (al_push),
      .push_data_i(mem_rdata_i),
      .push_off_i (soff),
      .push_n_i   (CNTW'(rd_take)),
      .pop_i      (al_pop),
      .wcnt_i     (CNTW'(wr_take)),
      .dst_off_i  (doff),
      .cnt_o      (al_cnt),
      .wdata_o    (al_wdata),
      .be_o       (al_be)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= S_IDLE;
         idx_q     <= '0;
         dptr_q    <= '0;
         rd_addr_q <= '0;
         wr_addr_q <= '0;
         nxt_q     <= '0;
         rd_left_q <= '0;
         wr_left_q <= '0;
         ctl_q     <= '0;
      end else begin
         case (state_q)
            S_IDLE: begin
               if (start_i) begin
                  dptr_q  <= head_i[ADDR_W-1:LB];
                  idx_q   <= '0;
                  state_q <= S_DRD;
               end
            end
            S_DRD: begin
               if (mem_gnt_i) state_q <= S_DRV;
            end
            S_DRV: begin
               if (mem_rvalid_i) begin
                  case (int'(idx_q))
                     DW_SRC:  rd_addr_q <= mem_rdata_i[ADDR_W-1:0];
                     DW_DST:  wr_addr_q <= mem_rdata_i[ADDR_W-1:0];
                     DW_LEN: begin
                        rd_left_q <= mem_rdata_i[LEN_W-1:0];
                        wr_left_q <= mem_rdata_i[LEN_W-1:0];
                     end
                     DW_NEXT: nxt_q <= mem_rdata_i[ADDR_W-1:0];
                     default: ctl_q <= mem_rdata_i;
                  endcase
                  if (!en_i) begin
                     state_q <= S_IDLE;
                  end else if (int'(idx_q) == DESC_WORDS - 1) begin
                     state_q <= S_SETUP;
                  end else begin
                     idx_q   <= idx_q + 1'b1;
                     state_q <= S_DRD;
                  end
               end
            end
            S_SETUP: begin
               state_q <= (wr_left_q == '0) ? S_WB : S_XFER;
            end
            S_XFER: begin
               if (!en_i)                  state_q <= S_IDLE;
               else if (wr_left_q == '0)   state_q <= S_WB;
               else if (can_wr)            state_q <= S_WR;
               else                        state_q <= S_RD;
            end
            S_RD: begin
               if (mem_gnt_i) state_q <= S_RDV;
            end
            S_RDV: begin
               if (mem_rvalid_i) begin
                  rd_addr_q <= rd_addr_q + ADDR_W'(rd_take);
                  rd_left_q <= rd_left_q - rd_take;
                  state_q   <= S_XFER;
               end
            end
            S_WR: begin
               if (mem_gnt_i) begin
                  wr_addr_q <= wr_addr_q + ADDR_W'(wr_take);
                  wr_left_q <= wr_left_q - wr_take;
                  state_q   <= S_XFER;
               end
            end
            S_WB: begin
               if (mem_gnt_i) begin
                  if (ctl_q[CTL_EOC] || !en_i) begin
                     state_q <= S_IDLE;
                  end else begin
                     dptr_q  <= nxt_q[ADDR_W-1:LB];
                     idx_q   <= '0;
                     state_q <= S_DRD;
                  end
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req_o   = 1'b0;
      mem_we_o    = 1'b0;
      mem_addr_o  = '0;
      mem_wdata_o = '0;
      mem_be_o    = '0;
      case (state_q)
         S_DRD: begin
            mem_req_o  = 1'b1;
            mem_addr_o = dptr_q + WAW'(idx_q);
         end
         S_RD: begin
            mem_req_o  = 1'b1;
            mem_addr_o = rd_addr_q[ADDR_W-1:LB];
         end
         S_WR: begin
            mem_req_o   = 1'b1;
            mem_we_o    = 1'b1;
            mem_addr_o  = wr_addr_q[ADDR_W-1:LB];
            mem_wdata_o = al_wdata;
            mem_be_o    = al_be;
         end
         S_WB: begin
            mem_req_o   = 1'b1;
            mem_we_o    = 1'b1;
            mem_addr_o  = dptr_q + WAW'(DW_CTL);
            mem_wdata_o = ctl_q | (DW'(1) << (DW - 1));
            mem_be_o    = '1;
         end
         default: ;
      endcase
   end

   assign busy_o    = (state_q != S_IDLE);
   assign set_irq_o = (state_q == S_WB) && mem_gnt_i && ctl_q[CTL_IRQ];
   assign set_eoc_o = (state_q == S_WB) && mem_gnt_i && ctl_q[CTL_EOC];

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R11
   AST_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == S_WB |-> rd_left_q == '0 && wr_left_q == '0 && al_cnt == '0);           // R4
   AST_BE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && mem_we_o |-> mem_be_o != '0);                                         // R4
   AST_HALT_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i && !mem_req_o |=> !(mem_req_o && (state_q == S_RD || state_q == S_WR)));    // R10
   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rvalid_i |-> !mem_req_o);                                                      // R11

endmodule

// File: rtl/sgdma_chan.sv
module sgdma_chan
   import sgdma_pkg::*;
#(
   parameter int NB         = 4,
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 16,
   parameter int HOLD_WORDS = 2,
   localparam int DW        = 8 * NB,
   localparam int LB        = $clog2(NB),
   localparam int WAW       = ADDR_W - LB
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           csr_wr_i,
   input  logic [1:0]     csr_addr_i,
   input  logic [DW-1:0]  csr_wdata_i,
   output logic [DW-1:0]  csr_rdata_o,
   output logic           irq_o,
   output logic           mem_req_o,
   output logic           mem_we_o,
   output logic [WAW-1:0] mem_addr_o,
   output logic [DW-1:0]  mem_wdata_o,
   output logic [NB-1:0]  mem_be_o,
   input  logic           mem_gnt_i,
   input  logic           mem_rvalid_i,
   input  logic [DW-1:0]  mem_rdata_i
);

   generate
      if (NB < 4 || (1 << LB) != NB) begin : g_bad_nb
         $error("sgdma_chan: NB must be a power of two, at least 4");
      end
      if (ADDR_W > DW || LEN_W > DW || ADDR_W <= LB) begin : g_bad_w
         $error("sgdma_chan: address and length fields must fit a word");
      end
   endgenerate

   logic              start, en, busy, set_irq, set_eoc;
   logic [ADDR_W-1:0] head;

   sgdma_csr #(
      .DW    (DW),
      .ADDR_W(ADDR_W)
   ) u_csr (
      .clk        (clk),
      .rst_n      (rst_n),
      .csr_wr_i   (csr_wr_i),
      .csr_addr_i (csr_addr_i),
      .csr_wdata_i(csr_wdata_i),
      .csr_rdata_o(csr_rdata_o),
      .busy_i     (busy),
      .set_irq_i  (set_irq),
      .set_eoc_i  (set_eoc),
      .start_o    (start),
      .en_o       (en),
      .head_o     (head),
      .irq_o      (irq_o)
   );

   sgdma_ctrl #(
      .NB        (NB),
      .ADDR_W    (ADDR_W),
      .LEN_W     (LEN_W),
      .HOLD_WORDS(HOLD_WORDS)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start),
      .en_i        (en),
      .head_i      (head),
      .busy_o      (busy),
      .set_irq_o   (set_irq),
      .set_eoc_o   (set_eoc),
      .mem_req_o   (mem_req_o),
      .mem_we_o    (mem_we_o),
      .mem_addr_o  (mem_addr_o),
      .mem_wdata_o (mem_wdata_o),
      .mem_be_o    (mem_be_o),
      .mem_gnt_i   (mem_gnt_i),
      .mem_rvalid_i(mem_rvalid_i),
      .mem_rdata_i (mem_rdata_i)
   );

endmodule

// File: tb/sgdma_chan_test.sv
module sgdma_chan_test;

   localparam int MEMB = 4096;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_wr = 1'b0;
   logic [1:0]  csr_addr = 2'd0;
   logic [31:0] csr_wdata = 32'd0;
   logic [31:0] csr_rdata;
   logic        irq;
   logic        mem_req, mem_we, mem_gnt;
   logic [29:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [3:0]  mem_be;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = 32'd0;

   logic [7:0]  mem_b [MEMB];
   logic [7:0]  lf = 8'hA7;
   int          acc = 0;
   int          nchk = 0;
   int          nfail = 0;
   int          cyc = 0;
   int          proto_bad = 0;
   logic        pend_prev = 1'b0;
   logic [29:0] addr_prev = '0;
   logic        we_prev = 1'b0;

   always #2 clk = ~clk;

   sgdma_chan uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .csr_wr_i    (csr_wr),
      .csr_addr_i  (csr_addr),
      .csr_wdata_i (csr_wdata),
      .csr_rdata_o (csr_rdata),
      .irq_o       (irq),
      .mem_req_o   (mem_req),
      .mem_we_o    (mem_we),
      .mem_addr_o  (mem_addr),
      .mem_wdata_o (mem_wdata),
      .mem_be_o    (mem_be),
      .mem_gnt_i   (mem_gnt),
      .mem_rvalid_i(mem_rvalid),
      .mem_rdata_i (mem_rdata)
   );

   assign mem_gnt = mem_req & (lf[0] | lf[3]);

   always @(posedge clk) begin
      lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      mem_rvalid <= 1'b0;
      if (mem_req && mem_gnt) begin
         int b;
         b = int'(mem_addr[9:0]) * 4;
         acc = acc + 1;
         if (!mem_we) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= {mem_b[b+3], mem_b[b+2], mem_b[b+1], mem_b[b]};
         end else begin
            for (int k = 0; k < 4; k++)
               if (mem_be[k]) mem_b[b+k] = mem_wdata[8*k +: 8];
         end
      end
   end

   // R11 request-hold monitor, sampled at the falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (pend_prev && !(mem_req && mem_addr == addr_prev && mem_we == we_prev))
            proto_bad = proto_bad + 1;
         pend_prev = mem_req && !mem_gnt;
         addr_prev = mem_addr;
         we_prev   = mem_we;
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      nchk = nchk + 1;
      if (!ok) begin
         nfail = nfail + 1;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic put_word(input int a, input logic [31:0] v);
      for (int k = 0; k < 4; k++) mem_b[a+k] = v[8*k +: 8];
   endtask

   function automatic logic [31:0] get_word(input int a);
      return {mem_b[a+3], mem_b[a+2], mem_b[a+1], mem_b[a]};
   endfunction

   task automatic csr_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
      @(negedge clk);
      csr_wr = 1'b0;
   endtask

   task automatic csr_read(input logic [1:0] a, output logic [31:0] d);
      csr_addr = a;
      #1;
      d = csr_rdata;
   endtask

   task automatic wait_idle(input bit need_eoc);
      logic [31:0] s;
      for (int t = 0; t < 20000; t++) begin
         @(negedge clk);
         csr_read(2'd2, s);
         if (!s[1] && (s[2] || !need_eoc)) return;
      end
      chk(1'b0, "R9 completion timeout", 0, 1);
   endtask

   function automatic logic [7:0] src_pat(input int v, input int i);
      return 8'((v * 7 + i * 13 + 1) & 255);
   endfunction

   task automatic run_vec(input int so, input int dof, input int len, input int v);
      logic [31:0] ctl, s;
      int          a0, bad, s_b, d_b;
      logic [7:0]  exp;
      for (int i = 0; i < 32; i++) begin
         mem_b[256 + i] = src_pat(v, i);
         mem_b[512 + i] = 8'hA5 ^ 8'(i);
      end
      ctl = 32'h00AB_0002 | 32'(len & 1);
      put_word(64, 32'(256 + so));
      put_word(68, 32'(516 + dof));
      put_word(72, 32'(len));
      put_word(76, 32'd0);
      put_word(80, ctl);
      csr_write(2'd1, 32'd64);
      a0 = acc;
      csr_write(2'd0, 32'd1);
      csr_read(2'd2, s);
      chk(s[1] == 1'b1, "R9 busy after start", longint'(s), 2);
      wait_idle(1'b1);
      bad = 0;
      for (int a = 0; a < 32; a++) begin
         d_b = a - 4 - dof;
         if (d_b >= 0 && d_b < len) begin
            s_b = so + d_b;
            exp = src_pat(v, s_b);
         end else begin
            exp = 8'hA5 ^ 8'(a);
         end
         if (mem_b[512 + a] !== exp) begin
            if (bad == 0)
               $display("FAIL R2 R3 R4 so=%0d do=%0d len=%0d byte %0d actual=%0h expected=%0h",
                        so, dof, len, a, mem_b[512 + a], exp);
            bad = bad + 1;
         end
      end
      nchk = nchk + 1;
      if (bad != 0) nfail = nfail + 1;
      chk(get_word(80) == (ctl | 32'h8000_0000), "R7 writeback", longint'(get_word(80)),
          longint'(ctl | 32'h8000_0000));
      chk(irq == ctl[0], "R8 irq on done", longint'(irq), longint'(ctl[0]));
      csr_read(2'd2, s);
      chk(s[2:1] == 2'b10, "R9 end flag and idle", longint'(s[2:1]), 2);
      if (len == 0)
         chk(acc - a0 == 6, "R6 zero length accesses", acc - a0, 6);
      csr_write(2'd2, 32'd1);
      chk(irq == 1'b0, "R8 clear", longint'(irq), 0);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc = cyc + 1;
         if (cyc > 150000) begin
            nfail = nfail + 1;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nchk + 1, nfail);
            $finish;
         end
      end
   end

   initial begin
      logic [31:0] s;
      int          v, a0;
      for (int i = 0; i < MEMB; i++) mem_b[i] = 8'h00;
      repeat (3) @(negedge clk);
      // R12 reset state
      csr_read(2'd2, s);
      chk(s == 32'd0, "R12 status at reset", longint'(s), 0);
      chk(irq == 1'b0, "R12 irq at reset", longint'(irq), 0);
      chk(mem_req == 1'b0, "R12 no request at reset", longint'(mem_req), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(mem_req == 1'b0, "R12 idle after reset", longint'(mem_req), 0);

      // R1 head pointer readback
      csr_write(2'd1, 32'h0000_0ABC);
      csr_read(2'd1, s);
      chk(s == 32'h0000_0ABC, "R1 head readback", longint'(s), 32'hABC);

      // R1 R2 R3 R4 R6 R7 R8 R9 sweep over alignments and lengths
      v = 0;
      for (int so = 0; so < 4; so++)
         for (int dof = 0; dof < 4; dof++)
            for (int len = 0; len < 10; len++) begin
               run_vec(so, dof, len, v);
               v = v + 1;
            end

      // R5 chain of three descriptors, middle one empty
      for (int i = 0; i < 32; i++) begin
         mem_b[768 + i] = src_pat(500, i);
         mem_b[896 + i] = 8'h3C ^ 8'(i);
      end
      put_word(64, 32'd769);  put_word(68, 32'd898); put_word(72, 32'd5);
      put_word(76, 32'd96);   put_word(80, 32'h0000_0000);
      put_word(96, 32'd770);  put_word(100, 32'd900); put_word(104, 32'd0);
      put_word(108, 32'd128); put_word(112, 32'h0000_0000);
      put_word(128, 32'd785); put_word(132, 32'd915); put_word(136, 32'd7);
      put_word(140, 32'd0);   put_word(144, 32'h0000_0003);
      csr_write(2'd1, 32'd64);
      csr_write(2'd0, 32'd1);
      wait_idle(1'b1);
      begin
         int bad;
         logic [7:0] exp;
         bad = 0;
         for (int a = 0; a < 32; a++) begin
            exp = 8'h3C ^ 8'(a);
            if (a >= 2 && a < 7)   exp = src_pat(500, 1 + a - 2);
            if (a >= 19 && a < 26) exp = src_pat(500, 17 + a - 19);
            if (mem_b[896 + a] !== exp) bad = bad + 1;
         end
         chk(bad == 0, "R5 chained copy", bad, 0);
      end
      chk(get_word(80)[31] && get_word(112)[31] && get_word(144)[31], "R5 all descriptors done",
          longint'({get_word(80)[31], get_word(112)[31], get_word(144)[31]}), 7);
      chk(irq == 1'b1, "R8 irq from last descriptor", longint'(irq), 1);
      csr_write(2'd2, 32'd1);

      // R10 halt mid-segment
      for (int i = 0; i < 1100; i++) mem_b[2304 + i] = 8'h5A;
      put_word(64, 32'd1280); put_word(68, 32'd2305); put_word(72, 32'd1000);
      put_word(76, 32'd0);    put_word(80, 32'h0000_0003);
      csr_write(2'd0, 32'd1);
      repeat (40) @(negedge clk);
      csr_write(2'd0, 32'd0);
      wait_idle(1'b0);
      csr_read(2'd2, s);
      chk(s[1] == 1'b0, "R10 busy clears on halt", longint'(s[1]), 0);
      a0 = acc;
      repeat (30) @(negedge clk);
      chk(acc == a0, "R10 no accesses after halt", acc - a0, 0);
      chk(get_word(80)[31] == 1'b0, "R10 no done writeback", longint'(get_word(80)), 3);
      chk(irq == 1'b0, "R10 no irq on halt", longint'(irq), 0);
      chk(mem_b[2305 + 999] == 8'h5A, "R10 tail untouched", longint'(mem_b[2305 + 999]), 8'h5A);

      // restart after halt
      run_vec(3, 1, 9, 777);

      chk(proto_bad == 0, "R11 request held until grant", proto_bad, 0);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule